// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Write and read positions are kept as binary counters in their own domains. Each counter crosses to the other domain as gray code through a two-flop synchroniser. The words themselves sit in a memory array written on the write clock, and a registered output stage is loaded on the read clock.

The read discipline is chosen while master reset is held. The choice is taken from a select input sampled on each clock edge during reset. With the select LOW the block works in request mode: every word, including the first, must be asked for with an active-low read enable. Here the read-side flag means "not empty" and the write-side flag means "not full". With the select HIGH the block works in fall-through mode: the oldest word moves into the output register without being asked for. Here the read-side flag means "valid data present" when LOW, and the write-side flag means "full" when HIGH. Because the output register holds one extra word, the capacity in fall-through mode grows from D to D+1. An active-low half-full flag is driven in both modes.

Top module: `twin_mode_fifo`

## Requirements
- R1: The mode is taken from `fallThroughSel` at clock edges while `mrstN` is LOW (0 = request mode, 1 = fall-through mode). Changing `fallThroughSel` after reset has no effect until the next reset.
- R2: While and after reset, with no writes: in request mode `rdFlag`=0 and `wrFlag`=1; in fall-through mode `rdFlag`=1 and `wrFlag`=0. In both modes `halfFullN`=1 and `rdData`=0.
- R3: In request mode a word leaves the FIFO only at a `rdClk` rising edge with `rdEnN`=0. It appears on `rdData` after that edge, and words leave in the order written. Without a read, `rdData` stays unchanged.
- R4: In request mode `rdFlag` rises after the third `rdClk` rising edge that follows the first write into an empty FIFO, and falls at the edge that reads the last word. With no reads, `wrFlag` falls at the write edge of the D-th word.
- R5: In fall-through mode the first word written into an empty FIFO appears on `rdData`, with `rdFlag`=0, after the third `rdClk` rising edge that follows its write edge, and not before. No read enable is needed.
- R6: In fall-through mode a valid word stays on `rdData` with `rdFlag`=0 until a `rdClk` edge with `rdEnN`=0 consumes it. `rdFlag` returns to 1 at the edge that consumes the last word.
- R7: In fall-through mode, once the first word is on the output, the FIFO accepts D+1 words in total. `wrFlag` rises to 1 at the write edge of word D+1.
- R8: A write attempted while the write side shows full is dropped: that word is never read out.
- R9: A read attempted while the FIFO is empty has no effect. In request mode `rdData` and `rdFlag` are unchanged; in fall-through mode `rdFlag` stays 1 and `rdData` is unchanged.
- R10: With no reads, `halfFullN` falls at the write edge of word D/2+1 in request mode. In fall-through mode, with the first word already on the output, it falls at the write edge of word D/2+2.
- R11: With writes and reads enabled in the same cycles, across empty and full, every word written is read exactly once and in order, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| mrstN | input | 1 | Master reset, active low, asynchronous |
| fallThroughSel | input | 1 | Mode select sampled during reset (1 = fall-through) |
| wrEnN | input | 1 | Write enable, active low |
| wrData | input | WIDTH | Write data |
| wrFlag | output | 1 | Request mode: LOW when full; fall-through mode: HIGH when full |
| halfFullN | output | 1 | LOW when more than half the memory is occupied |
| rdEnN | input | 1 | Read enable, active low |
| rdData | output | WIDTH | Read data from the output register |
| rdFlag | output | 1 | Request mode: LOW when empty; fall-through mode: LOW when data is valid |

## Verification
A push and a pop can land in the same cycle on their own clocks. This matters most at the two edges of occupancy: when a pop drains the memory while a new word is still crossing, or when a push meets a full memory whose freed slot has not yet been seen on the write side. The bench provokes this by running a writer and a reader at once. Each one drives its enable continuously and gates it only on its own flag, so the FIFO passes through both empty and full several times. The run is judged by the read-out sequence alone: every value must come out exactly once and in write order, in both modes.

// File: rtl/twin_fifo_pkg.sv
package twin_fifo_pkg;

  // Strobes from the control unit to the storage datapath.
  typedef struct packed {
    logic wrPush;  // write-clock domain: store wrData at wrAddr
    logic rdLoad;  // read-clock domain: load output register from rdAddr
  } fifo_strobe_t;

endpackage

// File: rtl/twin_fifo_datapath.sv
module twin_fifo_datapath
  import twin_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             mrstN,
  input  fifo_strobe_t     strb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.wrPush) store[wrAddr] <= wrData;
  end

  // Output register: serves as read latch in request mode and as the
  // extra storage slot in fall-through mode.
  always_ff @(posedge rdClk or negedge mrstN) begin
    if (!mrstN)           rdData <= '0;
    else if (strb.rdLoad) rdData <= store[rdAddr];
  end

endmodule

// File: rtl/twin_fifo_ctrl.sv
module twin_fifo_ctrl
  import twin_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          mrstN,
  input  logic          fallThroughSel,
  input  logic          wrEnN,
  input  logic          rdEnN,
  output fifo_strobe_t  strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          wrFlag,
  output logic          rdFlag,
  output logic          halfFullN
);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] toBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Mode latch, one copy per domain, loaded only while reset is held.
  logic wMode, rMode;
  always_ff @(posedge wrClk) if (!mrstN) wMode <= fallThroughSel;
  always_ff @(posedge rdClk) if (!mrstN) rMode <= fallThroughSel;

  // ---------------- write domain ----------------
  logic [PW-1:0] wBin, wGray, rSync1, rSync2;
  logic [PW-1:0] wBinNext, wCount;
  logic          fullReg, halfReg, wPush;

  assign wPush    = !wrEnN && !fullReg;
  assign wBinNext = wBin + PW'(wPush);
  assign wCount   = wBinNext - toBin(rSync2);

  always_ff @(posedge wrClk or negedge mrstN) begin
    if (!mrstN) begin
      wBin    <= '0;
      wGray   <= '0;
      rSync1  <= '0;
      rSync2  <= '0;
      fullReg <= 1'b0;
      halfReg <= 1'b0;
    end else begin
      wBin    <= wBinNext;
      wGray   <= toGray(wBinNext);
      rSync1  <= rGray;
      rSync2  <= rSync1;
      fullReg <= (wCount == PW'(DEPTH));
      halfReg <= (wCount > PW'(DEPTH / 2));
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rBin, rGray, wSync1, wSync2, rBinNext;
  logic          emptyReg, outValid, memEmpty, rPop;

  assign memEmpty = (rGray == wSync2);
  assign rPop     = rMode ? (!memEmpty && (!outValid || !rdEnN))
                          : (!rdEnN && !emptyReg);
  assign rBinNext = rBin + PW'(rPop);

  always_ff @(posedge rdClk or negedge mrstN) begin
    if (!mrstN) begin
      rBin     <= '0;
      rGray    <= '0;
      wSync1   <= '0;
      wSync2   <= '0;
      emptyReg <= 1'b1;
      outValid <= 1'b0;
    end else begin
      rBin     <= rBinNext;
      rGray    <= toGray(rBinNext);
      wSync1   <= wGray;
      wSync2   <= wSync1;
      emptyReg <= (toGray(rBinNext) == wSync2);
      if (rMode) begin
        if (rPop)        outValid <= 1'b1;
        else if (!rdEnN) outValid <= 1'b0;
      end
    end
  end

  assign strb.wrPush = wPush;
  assign strb.rdLoad = rPop;
  assign wrAddr      = wBin[AW-1:0];
  assign rdAddr      = rBin[AW-1:0];

  // Flag polarity and meaning depend on the latched mode.
  assign wrFlag    = wMode ? fullReg   : !fullReg;
  assign rdFlag    = rMode ? !outValid : !emptyReg;
  assign halfFullN = !halfReg;

endmodule

// File: rtl/twin_mode_fifo.sv
module twin_mode_fifo
  import twin_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             mrstN,
  input  logic             fallThroughSel,
  input  logic             wrEnN,
  input  logic [WIDTH-1:0] wrData,
  output logic             wrFlag,
  output logic             halfFullN,
  input  logic             rdEnN,
  output logic [WIDTH-1:0] rdData,
  output logic             rdFlag
);

  fifo_strobe_t  strb;
  logic [AW-1:0] wrAddr, rdAddr;

  twin_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN),
    .fallThroughSel(fallThroughSel),
    .wrEnN(wrEnN), .rdEnN(rdEnN),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrFlag(wrFlag), .rdFlag(rdFlag), .halfFullN(halfFullN)
  );

  twin_fifo_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dp (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/twin_mode_fifo_chk.sv
module twin_mode_fifo_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             mrstN,
  input logic             fallThroughSel,
  input logic             wrEnN,
  input logic             rdEnN,
  input logic             wrFlag,
  input logic             rdFlag,
  input logic [WIDTH-1:0] rdData,
  input logic [AW-1:0]    wrAddr,
  input logic [AW-1:0]    rdAddr
);

  logic ckModeW, ckModeR;
  always_ff @(posedge wrClk) if (!mrstN) ckModeW <= fallThroughSel;
  always_ff @(posedge rdClk) if (!mrstN) ckModeR <= fallThroughSel;

  logic fullSeen;
  assign fullSeen = ckModeW ? wrFlag : !wrFlag;

  // R8: an attempted write against a full FIFO does not move the write pointer
  assert_no_write_when_full_R8: assert property (
    @(posedge wrClk) disable iff (!mrstN)
    (fullSeen && !wrEnN) |=> $stable(wrAddr));

  // R9: request mode, read against empty leaves data and pointer alone
  assert_empty_read_ignored_R9: assert property (
    @(posedge rdClk) disable iff (!mrstN)
    (!ckModeR && !rdFlag && !rdEnN) |=> ($stable(rdData) && $stable(rdAddr)));

  // R6: fall-through mode, valid word held until consumed
  assert_fwft_hold_R6: assert property (
    @(posedge rdClk) disable iff (!mrstN)
    (ckModeR && !rdFlag && rdEnN) |=> (!rdFlag && $stable(rdData)));

  // R3: request mode, no read enable means no pop
  assert_read_needs_enable_R3: assert property (
    @(posedge rdClk) disable iff (!mrstN)
    (!ckModeR && rdEnN) |=> ($stable(rdData) && $stable(rdAddr)));

endmodule

bind twin_mode_fifo twin_mode_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN),
  .fallThroughSel(fallThroughSel),
  .wrEnN(wrEnN), .rdEnN(rdEnN),
  .wrFlag(wrFlag), .rdFlag(rdFlag), .rdData(rdData),
  .wrAddr(wrAddr), .rdAddr(rdAddr)
);

// File: tb/twin_mode_fifo_test.sv
module twin_mode_fifo_test;

  localparam int WIDTH = 8;
  localparam int DEPTH = 16;

  logic             wrClk = 0, rdClk = 0;
  logic             mrstN = 0, fallThroughSel = 0;
  logic             wrEnN = 1, rdEnN = 1;
  logic [WIDTH-1:0] wrData = '0;
  logic             wrFlag, halfFullN, rdFlag;
  logic [WIDTH-1:0] rdData;

  int testsRun = 0;
  int testsFailed = 0;

  twin_mode_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN),
    .fallThroughSel(fallThroughSel),
    .wrEnN(wrEnN), .wrData(wrData), .wrFlag(wrFlag), .halfFullN(halfFullN),
    .rdEnN(rdEnN), .rdData(rdData), .rdFlag(rdFlag)
  );

  // 125 MHz on both sides, read clock offset by 2 ns
  initial forever #4 wrClk = ~wrClk;
  initial begin
    #2;
    forever #4 rdClk = ~rdClk;
  end

  initial begin
    #(8 * 150000);
    testsFailed++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  task automatic checkEq(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic mode);
    mrstN = 0;
    fallThroughSel = mode;
    wrEnN = 1;
    rdEnN = 1;
    repeat (4) @(posedge wrClk);
    #1 mrstN = 1;
    fallThroughSel = !mode;   // must be ignored from now on (R1)
    repeat (2) @(negedge wrClk);
  endtask

  task automatic settle();
    repeat (8) @(negedge rdClk);
    repeat (2) @(negedge wrClk);
  endtask

  task automatic pushWord(input logic [WIDTH-1:0] d);
    @(negedge wrClk);
    wrData = d;
    wrEnN = 0;
    @(posedge wrClk);
    #1 wrEnN = 1;
  endtask

  task automatic popStd(output logic [WIDTH-1:0] d);
    @(negedge rdClk);
    rdEnN = 0;
    @(posedge rdClk);
    #1 rdEnN = 1;
    d = rdData;
  endtask

  task automatic popFwft(output logic [WIDTH-1:0] d);
    @(negedge rdClk);
    d = rdData;
    rdEnN = 0;
    @(posedge rdClk);
    #1 rdEnN = 1;
  endtask

  task automatic testStdReset();
    doReset(0);
    checkEq("R2 std rdFlag", rdFlag, 0);
    checkEq("R2 std wrFlag", wrFlag, 1);
    checkEq("R2 std halfFullN", halfFullN, 1);
    checkEq("R2 std rdData", rdData, 0);
  endtask

  task automatic testStdBasic();
    logic [WIDTH-1:0] d;
    doReset(0);
    popStd(d);
    checkEq("R9 std empty read data", d, 0);
    checkEq("R9 std empty read flag", rdFlag, 0);
    pushWord(8'hA5);
    repeat (2) @(posedge rdClk);
    #1 checkEq("R4 std not-empty before 3rd edge", rdFlag, 0);
    @(posedge rdClk);
    #1 checkEq("R4 std not-empty after 3rd edge", rdFlag, 1);
    checkEq("R3 no read no data", rdData, 0);
    checkEq("R1 mode kept after select change", rdFlag, 1);
    for (int i = 1; i < 4; i++) pushWord(8'hA5 + 8'(i));
    settle();
    for (int i = 0; i < 4; i++) begin
      popStd(d);
      checkEq("R3 std order", d, 8'hA5 + i);
    end
    checkEq("R4 std empty after last", rdFlag, 0);
  endtask

  task automatic testStdFull();
    logic [WIDTH-1:0] d;
    doReset(0);
    for (int i = 1; i <= DEPTH; i++) begin
      pushWord(8'h10 + 8'(i));
      if (i == DEPTH / 2)     checkEq("R10 std half at D/2", halfFullN, 1);
      if (i == DEPTH / 2 + 1) checkEq("R10 std half at D/2+1", halfFullN, 0);
      if (i == DEPTH - 1)     checkEq("R4 std not full at D-1", wrFlag, 1);
      if (i == DEPTH)         checkEq("R4 std full at D", wrFlag, 0);
    end
    pushWord(8'hEE);
    checkEq("R8 std still full", wrFlag, 0);
    settle();
    for (int i = 1; i <= DEPTH; i++) begin
      popStd(d);
      checkEq("R8 std full drain order", d, 8'h10 + i);
    end
    checkEq("R8 std empty after D", rdFlag, 0);
    popStd(d);
    checkEq("R8 std dropped word absent", d, 8'h10 + DEPTH);
  endtask

  task automatic testFwftReset();
    doReset(1);
    checkEq("R2 fwft rdFlag", rdFlag, 1);
    checkEq("R2 fwft wrFlag", wrFlag, 0);
    checkEq("R2 fwft halfFullN", halfFullN, 1);
    checkEq("R2 fwft rdData", rdData, 0);
  endtask

  task automatic testFwftFirst();
    logic [WIDTH-1:0] d;
    doReset(1);
    pushWord(8'h3C);
    repeat (2) @(posedge rdClk);
    #1 checkEq("R5 fwft not ready before 3rd edge", rdFlag, 1);
    @(posedge rdClk);
    #1 checkEq("R5 fwft ready after 3rd edge", rdFlag, 0);
    checkEq("R5 fwft first word", rdData, 8'h3C);
    checkEq("R1 fwft mode kept", rdFlag, 0);
    repeat (5) @(negedge rdClk);
    checkEq("R6 fwft held flag", rdFlag, 0);
    checkEq("R6 fwft held data", rdData, 8'h3C);
    popFwft(d);
    checkEq("R6 fwft popped", d, 8'h3C);
    checkEq("R6 fwft flag after last", rdFlag, 1);
    @(negedge rdClk) rdEnN = 0;
    @(posedge rdClk);
    #1 rdEnN = 1;
    checkEq("R9 fwft empty read flag", rdFlag, 1);
    checkEq("R9 fwft empty read data", rdData, 8'h3C);
  endtask

  task automatic testFwftFull();
    logic [WIDTH-1:0] d;
    doReset(1);
    pushWord(8'h80);
    settle();
    for (int i = 1; i <= DEPTH; i++) begin
      pushWord(8'h80 + 8'(i));
      if (i + 1 == DEPTH / 2 + 1) checkEq("R10 fwft half at D/2+1", halfFullN, 1);
      if (i + 1 == DEPTH / 2 + 2) checkEq("R10 fwft half at D/2+2", halfFullN, 0);
      if (i + 1 == DEPTH)         checkEq("R7 fwft not full at D", wrFlag, 0);
      if (i + 1 == DEPTH + 1)     checkEq("R7 fwft full at D+1", wrFlag, 1);
    end
    pushWord(8'hEE);
    checkEq("R8 fwft still full", wrFlag, 1);
    settle();
    for (int i = 0; i <= DEPTH; i++) begin
      popFwft(d);
      checkEq("R7 fwft drain order", d, 8'h80 + i);
    end
    checkEq("R8 fwft empty after D+1", rdFlag, 1);
  endtask

  task automatic testConcurrent(input logic mode);
    int errs = 0;
    int got = 0;
    doReset(mode);
    fork
      begin
        int sent = 0;
        while (sent < 40) begin
          @(negedge wrClk);
          if (mode ? !wrFlag : wrFlag) begin
            wrData = 8'(8'h40 + sent);
            wrEnN = 0;
            sent++;
          end else wrEnN = 1;
        end
        @(negedge wrClk) wrEnN = 1;
      end
      begin
        repeat (30) @(negedge rdClk);
        while (got < 40) begin
          @(negedge rdClk);
          if (mode) begin
            if (!rdFlag) begin
              if (rdData != 8'(8'h40 + got)) errs++;
              got++;
              rdEnN = 0;
            end else rdEnN = 1;
            @(posedge rdClk);
          end else begin
            logic en;
            en = rdFlag;
            rdEnN = !en;
            @(posedge rdClk);
            #1;
            if (en) begin
              if (rdData != 8'(8'h40 + got)) errs++;
              got++;
            end
          end
        end
        #1 rdEnN = 1;
      end
    join
    checkEq(mode ? "R11 fwft concurrent mismatches" : "R11 std concurrent mismatches", errs, 0);
    settle();
    checkEq("R11 empty after stream", rdFlag, mode ? 1 : 0);
  endtask

  initial begin
    testStdReset();
    testStdBasic();
    testStdFull();
    testFwftReset();
    testFwftFirst();
    testFwftFull();
    testConcurrent(0);
    testConcurrent(1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule